// File: doc/BRIEF.md
# Demagnetization-Time Frequency Trim Controller

This block closes a slow digital loop around a flyback converter's switching oscillator. The target is a transformer demagnetization time equal to half of one switching period. The block samples two inputs on a fast system clock: a switching-clock pulse, one per period, and a demagnetization-active level. It works in two-period cycles. In the first period it times the demagnetization interval. In the second period it times the whole period at half rate. At the end of the pair it compares the two times and stores the result in a flag. Once per switching period, a signed trim code moves one step in the direction that flag selects. The surrounding logic subtracts that code from the oscillator charging-current command.

A positive trim lowers the charging command, so a growing trim makes the period longer. That is the correction when demagnetization is too long. A shrinking trim makes the period shorter. The trim is frozen while the constant-current loop withholds its active-low enable. It is also frozen after reset until a built-in start-up lockout has counted enough switching periods, which lets the converter reach its first operating point before any trim is applied.

Top module: `dtc_trim_ctrl`

## Requirements
- R1: During and after reset, `trim_o` reads 0 and `flag_o` reads 0.
- R2: Both inputs pass a two-flop synchronizer, and edges are found on the system clock. The two-period working cycle alternates as follows. In the measuring period, the demagnetization timer counts one per system clock, starting at the synchronized rising edge of `demag_i` and stopping at its falling edge. In the reference period, the period timer counts one per two system clocks over the whole period.
- R3: At the switching-clock rising edge that ends a working cycle, `flag_o` becomes 0 if the demagnetization count is greater than the reference count. It becomes 1 if the demagnetization count is smaller. It keeps its value if the two are equal. With a 16-clock switching period the reference count is 7, so a 10-clock demagnetization gives 0, a 3-clock one gives 1, and a 7-clock one leaves the flag unchanged.
- R4: `flag_o` changes only at the edge that ends a working cycle. It holds across the whole of the following two periods.
- R5: Each enabled switching-clock rising edge moves `trim_o` by exactly one LSB. The move is up when the flag held before that edge is 0, and down when it is 1. At no other time does `trim_o` change.
- R6: `trim_o` is two's complement. It saturates at +511 and at -512 and never wraps.
- R7: While `cc_en_n_i` is 1, `trim_o` holds its value.
- R8: After reset, `trim_o` stays frozen through the first 2048 switching-clock rising edges. The 2049th rising edge is the first that can step it. This release is permanent until the next reset.
- R9: Only the first demagnetization pulse in a measuring period is timed. A later pulse in the same period adds nothing. Both timers restart from zero at every working-cycle boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the switching clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sw_clk_i | input | 1 | Switching-clock pulse, one per period, asynchronous |
| demag_i | input | 1 | Demagnetization-active level, asynchronous |
| cc_en_n_i | input | 1 | Active-low trim enable from the constant-current loop |
| trim_o | output | TRIM_W (10) | Signed trim code subtracted from the charging command |
| flag_o | output | 1 | Stored comparison: 0 means demagnetization longer than half a period |

## Verification
Two things can happen on the same switching-clock edge: the working-cycle comparison updates the flag, and the trim takes its per-period step. The step must follow the flag as it was before that edge, not the value just computed. The bench provokes this by switching from long to short demagnetization pulses, and then back. A behavioural reference model, compared every system clock, expects the step at the flag-flip edge to go in the old direction. The same edge-sharing is checked when the lockout releases, together with named checks on the exact trim value at the 2048th and 2049th periods.

// File: rtl/dtc_pkg.sv
package dtc_pkg;

   // Phase within the two-period working cycle.
   typedef enum logic {
      PH_MEAS = 1'b0,   // demagnetization interval is timed
      PH_REF  = 1'b1    // whole period is timed at half rate
   } dtc_phase_e;

   // Edge events of one synchronized input.
   typedef struct packed {
      logic rise;
      logic fall;
   } dtc_edge_t;

endpackage

// File: rtl/dtc_sync_edge.sv
module dtc_sync_edge
   import dtc_pkg::*;
#(
   parameter int STAGES = 2
) (
   input  logic      clk,
   input  logic      rst_n,
   input  logic      async_i,
   output dtc_edge_t ev_o
);

   logic [STAGES-1:0] chain_q;
   logic              last_q;

   initial begin
      assert (STAGES >= 2) else $error("dtc_sync_edge: STAGES must be at least 2");
   end

   generate
      for (genvar i = 0; i < STAGES; i++) begin : g_stage
         if (i == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain_q[0] <= 1'b0;
               else        chain_q[0] <= async_i;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain_q[i] <= 1'b0;
               else        chain_q[i] <= chain_q[i-1];
            end
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) last_q <= 1'b0;
      else        last_q <= chain_q[STAGES-1];
   end

   assign ev_o.rise =  chain_q[STAGES-1] & ~last_q;
   assign ev_o.fall = ~chain_q[STAGES-1] &  last_q;

endmodule

// File: rtl/dtc_startup_lock.sv
module dtc_startup_lock #(
   parameter int LOCK_DIV = 4096
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick_i,
   output logic release_o
);

   localparam int LOCK_W = $clog2(LOCK_DIV);

   logic [LOCK_W-1:0] div_q;
   logic              rel_q;

   initial begin
      assert (LOCK_DIV >= 4 && (LOCK_DIV & (LOCK_DIV - 1)) == 0)
         else $error("dtc_startup_lock: LOCK_DIV must be a power of two, at least 4");
   end

   // The divided clock is the counter MSB; its first transition
   // (after LOCK_DIV/2 ticks) opens the lock for good.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         div_q <= '0;
         rel_q <= 1'b0;
      end else begin
         if (!rel_q && tick_i) div_q <= div_q + 1'b1;
         rel_q <= rel_q | div_q[LOCK_W-1];
      end
   end

   assign release_o = rel_q;

   a_r8_release_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      rel_q |=> rel_q);

   a_r8_no_early_release: assert property (@(posedge clk) disable iff (!rst_n)
      (!rel_q && !div_q[LOCK_W-1]) |=> !rel_q);

endmodule

// File: rtl/dtc_period_cmp.sv
module dtc_period_cmp
   import dtc_pkg::*;
#(
   parameter int CNT_W = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sw_rise_i,
   input  logic dm_rise_i,
   input  logic dm_fall_i,
   output logic flag_o
);

   localparam logic [CNT_W-1:0] CNT_MAX = '1;

   dtc_phase_e        ph_q;
   logic [CNT_W-1:0]  td_q;
   logic [CNT_W-1:0]  ref_q;
   logic              act_q;
   logic              done_q;
   logic              half_q;
   logic              flag_q;
   logic              wp_end;

   initial begin
      assert (CNT_W >= 4) else $error("dtc_period_cmp: CNT_W too small");
   end

   assign wp_end = sw_rise_i && (ph_q == PH_REF);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph_q   <= PH_MEAS;
         td_q   <= '0;
         ref_q  <= '0;
         act_q  <= 1'b0;
         done_q <= 1'b0;
         half_q <= 1'b0;
         flag_q <= 1'b0;
      end else if (sw_rise_i) begin
         half_q <= 1'b0;
         act_q  <= 1'b0;
         if (ph_q == PH_REF) begin
            if (td_q > ref_q)      flag_q <= 1'b0;
            else if (td_q < ref_q) flag_q <= 1'b1;
            td_q   <= '0;
            ref_q  <= '0;
            done_q <= 1'b0;
            ph_q   <= PH_MEAS;
         end else begin
            done_q <= 1'b1;
            ph_q   <= PH_REF;
         end
      end else if (ph_q == PH_MEAS) begin
         if (act_q && td_q != CNT_MAX) td_q <= td_q + 1'b1;
         if (act_q && dm_fall_i) begin
            act_q  <= 1'b0;
            done_q <= 1'b1;
         end else if (!act_q && !done_q && dm_rise_i) begin
            act_q <= 1'b1;
         end
      end else begin
         half_q <= ~half_q;
         if (half_q && ref_q != CNT_MAX) ref_q <= ref_q + 1'b1;
      end
   end

   assign flag_o = flag_q;

   a_r4_flag_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !wp_end |=> $stable(flag_q));

   a_r9_clear_at_boundary: assert property (@(posedge clk) disable iff (!rst_n)
      wp_end |=> (td_q == '0 && ref_q == '0));

   a_r9_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      (done_q && !sw_rise_i) |=> !act_q);

   a_r2_td_frozen_in_ref: assert property (@(posedge clk) disable iff (!rst_n)
      (ph_q == PH_REF && !sw_rise_i) |=> $stable(td_q));

   a_r2_ref_idle_in_meas: assert property (@(posedge clk) disable iff (!rst_n)
      (ph_q == PH_MEAS && !sw_rise_i) |=> $stable(ref_q));

   a_r3_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      (td_q == CNT_MAX && !sw_rise_i) |=> td_q == CNT_MAX);

endmodule

// File: rtl/dtc_trim_step.sv
module dtc_trim_step #(
   parameter int TRIM_W = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              step_i,
   input  logic              up_i,
   output logic [TRIM_W-1:0] trim_o
);

   localparam logic signed [TRIM_W-1:0] T_MAX = {1'b0, {(TRIM_W-1){1'b1}}};
   localparam logic signed [TRIM_W-1:0] T_MIN = {1'b1, {(TRIM_W-1){1'b0}}};
   localparam logic signed [TRIM_W-1:0] T_ONE = {{(TRIM_W-1){1'b0}}, 1'b1};

   logic signed [TRIM_W-1:0] trim_q;

   initial begin
      assert (TRIM_W >= 2) else $error("dtc_trim_step: TRIM_W too small");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         trim_q <= '0;
      end else if (step_i) begin
         if (up_i && trim_q != T_MAX)       trim_q <= trim_q + T_ONE;
         else if (!up_i && trim_q != T_MIN) trim_q <= trim_q - T_ONE;
      end
   end

   assign trim_o = trim_q;

   a_r5_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !step_i |=> $stable(trim_q));

   a_r5_step_up: assert property (@(posedge clk) disable iff (!rst_n)
      (step_i && up_i && trim_q != T_MAX) |=> trim_q == $past(trim_q) + T_ONE);

   a_r5_step_down: assert property (@(posedge clk) disable iff (!rst_n)
      (step_i && !up_i && trim_q != T_MIN) |=> trim_q == $past(trim_q) - T_ONE);

   a_r6_sat_high: assert property (@(posedge clk) disable iff (!rst_n)
      (step_i && up_i && trim_q == T_MAX) |=> trim_q == T_MAX);

   a_r6_sat_low: assert property (@(posedge clk) disable iff (!rst_n)
      (step_i && !up_i && trim_q == T_MIN) |=> trim_q == T_MIN);

endmodule

// File: rtl/dtc_trim_ctrl.sv
module dtc_trim_ctrl
   import dtc_pkg::*;
#(
   parameter int CNT_W       = 16,
   parameter int TRIM_W      = 10,
   parameter int LOCK_DIV    = 4096,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sw_clk_i,
   input  logic              demag_i,
   input  logic              cc_en_n_i,
   output logic [TRIM_W-1:0] trim_o,
   output logic              flag_o
);

   dtc_edge_t sw_ev;
   dtc_edge_t dm_ev;
   logic      released;
   logic      flag;
   logic      step;

   dtc_sync_edge #(.STAGES(SYNC_STAGES)) u_sw_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .async_i (sw_clk_i),
      .ev_o    (sw_ev)
   );

   dtc_sync_edge #(.STAGES(SYNC_STAGES)) u_dm_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .async_i (demag_i),
      .ev_o    (dm_ev)
   );

   dtc_startup_lock #(.LOCK_DIV(LOCK_DIV)) u_lock (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick_i    (sw_ev.rise),
      .release_o (released)
   );

   dtc_period_cmp #(.CNT_W(CNT_W)) u_cmp (
      .clk       (clk),
      .rst_n     (rst_n),
      .sw_rise_i (sw_ev.rise),
      .dm_rise_i (dm_ev.rise),
      .dm_fall_i (dm_ev.fall),
      .flag_o    (flag)
   );

   // One trim step per enabled switching period, direction from the
   // flag stored before this edge.
   assign step = sw_ev.rise & released & ~cc_en_n_i;

   dtc_trim_step #(.TRIM_W(TRIM_W)) u_trim (
      .clk    (clk),
      .rst_n  (rst_n),
      .step_i (step),
      .up_i   (~flag),
      .trim_o (trim_o)
   );

   assign flag_o = flag;

   a_r7_cc_hold: assert property (@(posedge clk) disable iff (!rst_n)
      cc_en_n_i |=> $stable(trim_o));

   a_r8_locked_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !released |=> $stable(trim_o));

   a_r5_no_step_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
      sw_ev.fall |=> $stable(trim_o));

   a_r4_flag_only_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
      !sw_ev.rise |=> $stable(flag_o));

endmodule

// File: tb/dtc_trim_ctrl_tb.sv
`timescale 1ns/1ps
module dtc_trim_ctrl_tb;

   localparam int TRIM_W = 10;
   localparam int PER    = 16;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic sw_clk_i = 1'b0;
   logic demag_i = 1'b0;
   logic cc_en_n_i = 1'b1;
   logic [TRIM_W-1:0] trim_o;
   logic flag_o;

   int n_checks = 0;
   int n_errors = 0;
   bit finished = 1'b0;

   always #2.5 clk = ~clk;

   dtc_trim_ctrl u_dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .sw_clk_i  (sw_clk_i),
      .demag_i   (demag_i),
      .cc_en_n_i (cc_en_n_i),
      .trim_o    (trim_o),
      .flag_o    (flag_o)
   );

   // ---------------- behavioural reference model ----------------
   bit m_sw[3];
   bit m_dm[3];
   int m_rises, m_td, m_ref, m_trim;
   bit m_ok, m_ref_phase, m_act, m_done, m_half, m_flag;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_sw = '{0, 0, 0};
         m_dm = '{0, 0, 0};
         m_rises = 0; m_td = 0; m_ref = 0; m_trim = 0;
         m_ok = 0; m_ref_phase = 0; m_act = 0; m_done = 0; m_half = 0; m_flag = 0;
      end else begin
         bit sr, dr, df, old_flag;
         sr = m_sw[1] && !m_sw[2];
         dr = m_dm[1] && !m_dm[2];
         df = !m_dm[1] && m_dm[2];
         old_flag = m_flag;
         // trim step uses the flag held before this edge
         if (sr && m_ok && !cc_en_n_i) begin
            if (!old_flag && m_trim < 511) m_trim = m_trim + 1;
            else if (old_flag && m_trim > -512) m_trim = m_trim - 1;
         end
         m_ok = m_ok || (m_rises >= 2048);
         if (sr) m_rises = m_rises + 1;
         if (sr) begin
            m_half = 0; m_act = 0;
            if (m_ref_phase) begin
               if (m_td > m_ref) m_flag = 0;
               else if (m_td < m_ref) m_flag = 1;
               m_td = 0; m_ref = 0; m_done = 0; m_ref_phase = 0;
            end else begin
               m_done = 1; m_ref_phase = 1;
            end
         end else if (!m_ref_phase) begin
            if (m_act) m_td = m_td + 1;
            if (m_act && df) begin m_act = 0; m_done = 1; end
            else if (!m_act && !m_done && dr) m_act = 1;
         end else begin
            if (m_half) m_ref = m_ref + 1;
            m_half = !m_half;
         end
         m_sw[2] = m_sw[1]; m_sw[1] = m_sw[0]; m_sw[0] = sw_clk_i;
         m_dm[2] = m_dm[1]; m_dm[1] = m_dm[0]; m_dm[0] = demag_i;
      end
   end

   // ---------------- per-clock comparison ----------------
   always @(negedge clk) begin
      if (rst_n && !finished) begin
         n_checks++;
         if ($signed(trim_o) != m_trim) begin
            n_errors++;
            $display("FAIL R5 per-clock trim: actual=%0d expected=%0d at %0t",
                     $signed(trim_o), m_trim, $time);
         end
         n_checks++;
         if (flag_o !== m_flag) begin
            n_errors++;
            $display("FAIL R3 per-clock flag: actual=%0b expected=%0b at %0t",
                     flag_o, m_flag, $time);
         end
      end
   end

   task automatic check(input string tag, input int actual, input int expected);
      n_checks++;
      if (actual != expected) begin
         n_errors++;
         $display("FAIL %s: actual=%0d expected=%0d", tag, actual, expected);
      end
   endtask

   // One switching period: sw pulse for 2 clocks, up to two demag pulses.
   task automatic period(input int s1, input int d1, input int s2, input int d2);
      for (int c = 0; c < PER; c++) begin
         @(negedge clk);
         sw_clk_i = (c < 2);
         demag_i  = (c >= s1 && c < s1 + d1) || (c >= s2 && c < s2 + d2);
      end
   endtask

   task automatic run(input int n, input int d);
      for (int i = 0; i < n; i++) period(3, d, 0, 0);
   endtask

   initial begin
      repeat (4) @(negedge clk);
      check("R1 reset trim", $signed(trim_o), 0);
      check("R1 reset flag", flag_o, 0);
      rst_n = 1'b1;
      cc_en_n_i = 1'b0;
      @(negedge clk);
      check("R1 trim after reset", $signed(trim_o), 0);

      // long demagnetization: flag stays 0, trim locked
      run(2048, 10);
      check("R8 trim frozen after 2048 periods", $signed(trim_o), 0);
      check("R2 long demag flag", flag_o, 0);
      run(1, 10);
      check("R8 first step on period 2049", $signed(trim_o), 1);
      run(1, 10);
      check("R5 second step up", $signed(trim_o), 2);
      run(520, 10);
      check("R6 saturate high", $signed(trim_o), 511);

      // constant-current enable withheld: trim holds, flag still updates
      cc_en_n_i = 1'b1;
      run(10, 3);
      check("R7 trim held while disabled", $signed(trim_o), 511);
      check("R3 short demag flag", flag_o, 1);
      cc_en_n_i = 1'b0;
      run(5, 3);
      check("R5 step down", $signed(trim_o), 506);
      run(1100, 3);
      check("R6 saturate low", $signed(trim_o), -512);

      // equality keeps the flag
      run(4, 10);
      check("R3 long after short", flag_o, 0);
      run(4, 7);
      check("R3 equal keeps 0", flag_o, 0);
      run(4, 3);
      check("R3 short again", flag_o, 1);
      run(4, 7);
      check("R3 equal keeps 1", flag_o, 1);

      // only the first demag pulse in the measuring period counts
      run(4, 10);
      check("R9 setup long", flag_o, 0);
      for (int i = 0; i < 4; i++) period(2, 3, 7, 8);
      check("R9 second pulse ignored", flag_o, 1);

      // R4 hold inside a working cycle, re-enter long pattern
      period(3, 10, 0, 0);
      check("R4 flag held mid-cycle", flag_o, 1);
      run(3, 10);
      check("R4 flag updated at cycle end", flag_o, 0);

      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         n_checks++;
         n_errors++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
         $finish;
      end
   end

endmodule